// File: doc/BRIEF.md
# DSP Condition Code Flag Unit

This block holds the 16-bit status word of a fixed-point DSP datapath. Whenever the ALU hands over a finished operation, the block derives status flags from the 40-bit result and from side information: carry out of bit 31, the bit-31 signs of both operands, the next quotient bit, the bit shifted out or tested, and a 40-bit overflow indication. Each flag has its own update rule, which depends on the operation class. Two flags are sticky: the normalized memory and the overflow memory. A conditional-test strobe clears both.

The two top bits of the same word hold a loop-nesting pointer. The pointer is stepped by loop enter and exit strobes and decoded into the register bank that the current loop level uses. The ALU result stream is presented with a valid/ready pair. The block never applies back-pressure: ready is held high, and a result counts as accepted on every clock edge where valid is high. The loop strobes and the test strobe are plain single-cycle pulses.

Top module: `dsp_ccr_unit`

## Requirements
- R1: After reset the status word reads 0x0000, the bank output reads 01 and the overflow error is low. Bits 13, 1 and 0 of the status word always read 0, and ready is always high.
- R2: The flags sit at bit 12 TST, 11 C31, 10 NQ, 9 CS, 8 PAR, 7 MN, 6 N, 5 EXT, 4 MOVF, 3 OVF, 2 Z. Every accepted operation loads Z (1 when all 40 result bits are zero), N (result bit 39), EXT (1 when result bits 39..31 are not all equal) and OVF (the overflow input). All flags update on the clock edge that accepts the operation.
- R3: Every accepted operation loads PAR with result bit 16.
- R4: C31 is loaded with the carry input on every accepted operation except the double-multiply class (code 4), which leaves it unchanged. The class codes are 0 arithmetic, 1 compare-signs, 2 signed divide step, 3 quotient divide step, 4 double multiply, 5 pure shift, 6 bit test, 7 remainder correction.
- R5: NQ is loaded with the inverse of the next quotient bit, and only on classes 2 and 3. Every other class leaves it unchanged.
- R6: CS is loaded with the XOR of the two operand signs, and only on class 1.
- R7: MN is set by an accepted result that is normalized, meaning bits 39..32 equal bit 31 and bit 31 differs from bit 30. MN then holds until the test strobe clears it. When a set and a test arrive in the same cycle, MN reads 1.
- R8: TST is loaded with the shifted-out or tested bit on classes 5 and 6 only.
- R9: A loop enter strobe increments the pointer in bits 15:14 and stops at 11. An enter at 11 raises the error output for the following cycle. An exit strobe decrements the pointer and stops at 00. Enter and exit together leave the pointer unchanged.
- R10: The bank output is 01 for pointer values 00 and 01, 10 for pointer value 10, and 11 for pointer value 11.
- R11: In a cycle where valid is low, bits 12..2 keep their values unless the test strobe clears a sticky flag.
- R12: MOVF is set whenever an accepted operation has the overflow input high. It holds until the test strobe clears it, and a new set wins over a test in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_valid | input | 1 | ALU operation result present |
| alu_ready | output | 1 | Always high, the block never stalls |
| alu_class | input | 3 | Operation class code |
| alu_result | input | 40 | ALU result |
| alu_carry31 | input | 1 | Carry out of bit 31 |
| alu_sign_a | input | 1 | Bit-31 sign of operand A |
| alu_sign_b | input | 1 | Bit-31 sign of operand B |
| alu_next_q | input | 1 | Next quotient bit from a divide step |
| alu_bit_out | input | 1 | Bit shifted out or tested |
| alu_ovf | input | 1 | 40-bit overflow of the operation |
| cond_test | input | 1 | Conditional test strobe, clears sticky flags |
| loop_enter | input | 1 | Loop entry strobe |
| loop_exit | input | 1 | Loop exit strobe |
| ccr_q | output | 16 | Status word |
| loop_bank | output | 2 | Register bank for the current loop level |
| loop_ovf_err | output | 1 | Loop nesting overflow pulse |

## Verification
The hardest situation to reach is the collision on a sticky flag: a normalizing result has to be accepted in exactly the cycle that carries the test strobe, and MN has to be set beforehand so that the clear is observable. The stimulus first sets MN, then sends a non-normalized result to show that MN holds, then issues a lone test to clear it, and finally drives a normalized result together with the test strobe. The overflow memory goes through the same steps. For the loop pointer, the stimulus walks it up to level 3 and issues one more enter, which exposes both the saturation and the one-cycle error pulse.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_ARITH = 3'd0,
    OP_CMPS  = 3'd1,
    OP_DIVS  = 3'd2,
    OP_DIVQ  = 3'd3,
    OP_DMUL  = 3'd4,
    OP_SHIFT = 3'd5,
    OP_BTEST = 3'd6,
    OP_RCORR = 3'd7
  } op_class_e;

  // Ordered from status bit 12 down to bit 2.
  typedef struct packed {
    logic tst;
    logic c31;
    logic nq;
    logic cs;
    logic par;
    logic mn;
    logic n;
    logic ext;
    logic movf;
    logic ovf;
    logic z;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/ccr_result_decode.sv
module ccr_result_decode #(
  parameter int RES_W    = 40,
  parameter int SIGN_BIT = 31,
  parameter int PAR_BIT  = 16
) (
  input  logic [RES_W-1:0] result,
  output logic             is_zero,
  output logic             is_ext,
  output logic             is_norm,
  output logic             msb,
  output logic             par_bit
);
  localparam int GUARD_W = RES_W - SIGN_BIT;

  logic [GUARD_W-1:0] guard;

  assign guard   = result[RES_W-1:SIGN_BIT];
  assign is_zero = ~|result;
  assign is_ext  = !((&guard) || (~|guard));
  assign is_norm = !is_ext && (result[SIGN_BIT] != result[SIGN_BIT-1]);
  assign msb     = result[RES_W-1];
  assign par_bit = result[PAR_BIT];
endmodule

// File: rtl/ccr_flag_regs.sv
module ccr_flag_regs
  import ccr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  op_class_e cls,
  input  logic      is_zero,
  input  logic      is_ext,
  input  logic      is_norm,
  input  logic      msb,
  input  logic      par_bit,
  input  logic      carry31,
  input  logic      sign_a,
  input  logic      sign_b,
  input  logic      next_q,
  input  logic      bit_out,
  input  logic      ovf_in,
  input  logic      cond_test,
  output flags_t    flags
);
  flags_t nxt;

  always_comb begin
    nxt = flags;
    if (upd) begin
      nxt.z   = is_zero;
      nxt.n   = msb;
      nxt.ext = is_ext;
      nxt.ovf = ovf_in;
      nxt.par = par_bit;
      if (cls != OP_DMUL)
        nxt.c31 = carry31;
      if (cls == OP_DIVS || cls == OP_DIVQ)
        nxt.nq = ~next_q;
      if (cls == OP_CMPS)
        nxt.cs = sign_a ^ sign_b;
      if (cls == OP_SHIFT || cls == OP_BTEST)
        nxt.tst = bit_out;
    end
    // Sticky flags: a fresh set outranks a clearing test.
    if (upd && is_norm)
      nxt.mn = 1'b1;
    else if (cond_test)
      nxt.mn = 1'b0;
    if (upd && ovf_in)
      nxt.movf = 1'b1;
    else if (cond_test)
      nxt.movf = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= nxt;
  end
endmodule

// File: rtl/ccr_loop_stack.sv
module ccr_loop_stack #(
  parameter int LSP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             leave,
  output logic [LSP_W-1:0] lsp,
  output logic [LSP_W-1:0] bank,
  output logic             ovf_err
);
  localparam logic [LSP_W-1:0] TOP = {LSP_W{1'b1}};
  localparam logic [LSP_W-1:0] ONE = {{(LSP_W-1){1'b0}}, 1'b1};

  logic push_only, pop_only;

  assign push_only = enter && !leave;
  assign pop_only  = leave && !enter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsp     <= '0;
      ovf_err <= 1'b0;
    end else begin
      ovf_err <= push_only && (lsp == TOP);
      if (push_only && lsp != TOP)
        lsp <= lsp + ONE;
      else if (pop_only && lsp != '0)
        lsp <= lsp - ONE;
    end
  end

  // Level 0 (no loop) shares the first bank.
  assign bank = (lsp == '0) ? ONE : lsp;
endmodule

// File: rtl/dsp_ccr_unit.sv
module dsp_ccr_unit #(
  parameter int RES_W    = 40,
  parameter int SIGN_BIT = 31,
  parameter int PAR_BIT  = 16,
  parameter int LSP_W    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alu_valid,
  output logic                            alu_ready,
  input  logic [2:0]                      alu_class,
  input  logic [RES_W-1:0]                alu_result,
  input  logic                            alu_carry31,
  input  logic                            alu_sign_a,
  input  logic                            alu_sign_b,
  input  logic                            alu_next_q,
  input  logic                            alu_bit_out,
  input  logic                            alu_ovf,
  input  logic                            cond_test,
  input  logic                            loop_enter,
  input  logic                            loop_exit,
  output logic [LSP_W+ccr_pkg::FLAG_W+2:0] ccr_q,
  output logic [LSP_W-1:0]                loop_bank,
  output logic                            loop_ovf_err
);
  import ccr_pkg::*;

  logic       is_zero, is_ext, is_norm, msb, par_bit;
  flags_t     flags;
  logic [LSP_W-1:0] lsp;
  op_class_e  cls;

  assign alu_ready = 1'b1;
  assign cls       = op_class_e'(alu_class);

  ccr_result_decode #(
    .RES_W(RES_W), .SIGN_BIT(SIGN_BIT), .PAR_BIT(PAR_BIT)
  ) u_dec (
    .result(alu_result), .is_zero(is_zero), .is_ext(is_ext),
    .is_norm(is_norm), .msb(msb), .par_bit(par_bit)
  );

  ccr_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .upd(alu_valid && alu_ready), .cls(cls),
    .is_zero(is_zero), .is_ext(is_ext), .is_norm(is_norm), .msb(msb),
    .par_bit(par_bit), .carry31(alu_carry31), .sign_a(alu_sign_a),
    .sign_b(alu_sign_b), .next_q(alu_next_q), .bit_out(alu_bit_out),
    .ovf_in(alu_ovf), .cond_test(cond_test), .flags(flags)
  );

  ccr_loop_stack #(.LSP_W(LSP_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .enter(loop_enter), .leave(loop_exit),
    .lsp(lsp), .bank(loop_bank), .ovf_err(loop_ovf_err)
  );

  assign ccr_q = {lsp, 1'b0, flags, 2'b00};
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        alu_valid,
  input logic [2:0]  alu_class,
  input logic [39:0] alu_result,
  input logic        loop_enter,
  input logic        loop_exit,
  input logic [15:0] ccr_q,
  input logic [1:0]  loop_bank,
  input logic        loop_ovf_err
);
  logic norm_seen;
  assign norm_seen = (alu_result[39:31] == 9'h000 || alu_result[39:31] == 9'h1FF)
                     && (alu_result[31] != alu_result[30]);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_q[13] == 1'b0 && ccr_q[1:0] == 2'b00);

  assert_par_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |=> ccr_q[8] == $past(alu_result[16]));

  assert_c31_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_class == 3'd4) |=> $stable(ccr_q[11]));

  assert_nq_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_valid && (alu_class == 3'd2 || alu_class == 3'd3)) |=> $stable(ccr_q[10]));

  assert_mn_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && norm_seen) |=> ccr_q[7]);

  assert_loop_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_enter && !loop_exit && ccr_q[15:14] == 2'b11)
      |=> (ccr_q[15:14] == 2'b11 && loop_ovf_err));

  assert_bank_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_bank != 2'b00);
endmodule

bind dsp_ccr_unit ccr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_class(alu_class),
  .alu_result(alu_result), .loop_enter(loop_enter), .loop_exit(loop_exit),
  .ccr_q(ccr_q), .loop_bank(loop_bank), .loop_ovf_err(loop_ovf_err)
);

// File: tb/dsp_ccr_unit_tb.sv
module dsp_ccr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_valid = 1'b0;
  logic        alu_ready;
  logic [2:0]  alu_class = 3'd0;
  logic [39:0] alu_result = '0;
  logic        alu_carry31 = 1'b0, alu_sign_a = 1'b0, alu_sign_b = 1'b0;
  logic        alu_next_q = 1'b0, alu_bit_out = 1'b0, alu_ovf = 1'b0;
  logic        cond_test = 1'b0, loop_enter = 1'b0, loop_exit = 1'b0;
  logic [15:0] ccr_q;
  logic [1:0]  loop_bank;
  logic        loop_ovf_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dsp_ccr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_ready(alu_ready),
    .alu_class(alu_class), .alu_result(alu_result), .alu_carry31(alu_carry31),
    .alu_sign_a(alu_sign_a), .alu_sign_b(alu_sign_b), .alu_next_q(alu_next_q),
    .alu_bit_out(alu_bit_out), .alu_ovf(alu_ovf), .cond_test(cond_test),
    .loop_enter(loop_enter), .loop_exit(loop_exit), .ccr_q(ccr_q),
    .loop_bank(loop_bank), .loop_ovf_err(loop_ovf_err)
  );

  // {class, result, c31, sign_a, sign_b, next_q, bit_out, ovf, expected word}
  localparam int NV = 9;
  localparam logic [64:0] VEC [NV] = '{
    {3'd0, 40'h00_0000_0000, 6'b100000, 16'h0804},  // R2 Z, R4 carry
    {3'd0, 40'h00_4000_0000, 6'b000000, 16'h0080},  // R7 normalized
    {3'd1, 40'hFF_8001_0000, 6'b110000, 16'h0BC0},  // R6 CS, R3 PAR
    {3'd2, 40'h01_0000_0000, 6'b011000, 16'h0420},  // R5 NQ, R6 CS ignored
    {3'd4, 40'h80_0000_0000, 6'b100001, 16'h0078},  // R4 DMUL, R12 MOVF
    {3'd5, 40'h00_0001_0000, 6'b000010, 16'h1100},  // R8 shift
    {3'd6, 40'h00_0000_0001, 6'b000110, 16'h1000},  // R8 test, R5 ignored
    {3'd3, 40'h00_C000_0000, 6'b100100, 16'h0820},  // R5 DIVQ, R2 EXT
    {3'd7, 40'hFF_FFFF_FFFF, 6'b010000, 16'h0140}   // R2 N, R6 ignored
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    alu_valid = 1'b0; cond_test = 1'b0; loop_enter = 1'b0; loop_exit = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic [2:0] c, input logic [39:0] r, input logic [5:0] s);
    alu_valid = 1'b1; alu_class = c; alu_result = r;
    {alu_carry31, alu_sign_a, alu_sign_b, alu_next_q, alu_bit_out, alu_ovf} = s;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset word", ccr_q, 16'h0000);
    chk("R1 reset bank", loop_bank, 2'b01);
    chk("R1 reset err", loop_ovf_err, 1'b0);
    chk("R1 ready", alu_ready, 1'b1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      drive(VEC[i][64:62], VEC[i][61:22], VEC[i][21:16]);
      step();
      idle();
      chk($sformatf("R2 vector %0d", i), ccr_q, VEC[i][15:0]);
    end

    // Unchanged flags across classes that must not load them.
    do_reset();
    drive(3'd0, 40'h0, 6'b100000); step(); idle();
    chk("R4 carry loaded", ccr_q, 16'h0804);
    drive(3'd4, 40'h1, 6'b000000); step(); idle();
    chk("R4 DMUL keeps C31", ccr_q, 16'h0800);
    drive(3'd2, 40'h1, 6'b000000); step(); idle();
    chk("R5 DIVS loads NQ", ccr_q, 16'h0400);
    drive(3'd0, 40'h1, 6'b000000); step(); idle();
    chk("R5 arith keeps NQ", ccr_q, 16'h0400);
    drive(3'd1, 40'h0, 6'b110011); alu_valid = 1'b0; step(); idle();
    chk("R11 no valid no change", ccr_q, 16'h0400);

    // Sticky normalized flag.
    do_reset();
    drive(3'd0, 40'h00_4000_0000, 6'b000000); step(); idle();
    drive(3'd0, 40'h1, 6'b000000); step(); idle();
    chk("R7 MN holds", ccr_q, 16'h0080);
    cond_test = 1'b1; step(); idle();
    chk("R7 test clears MN", ccr_q, 16'h0000);
    drive(3'd0, 40'hFF_8000_0000, 6'b000000); cond_test = 1'b1; step(); idle();
    chk("R7 set wins over test", ccr_q[7], 1'b1);

    // Sticky overflow memory.
    do_reset();
    drive(3'd0, 40'h1, 6'b000001); step(); idle();
    chk("R12 OVF and MOVF", ccr_q, 16'h0018);
    drive(3'd0, 40'h1, 6'b000000); step(); idle();
    chk("R12 MOVF holds", ccr_q, 16'h0010);
    drive(3'd0, 40'h1, 6'b000001); cond_test = 1'b1; step(); idle();
    chk("R12 set wins over test", ccr_q, 16'h0018);
    cond_test = 1'b1; step(); idle();
    chk("R12 test clears MOVF", ccr_q, 16'h0008);

    // Loop nesting pointer.
    do_reset();
    loop_enter = 1'b1; step(); idle();
    chk("R9 level 1", ccr_q[15:14], 2'b01);
    chk("R10 bank at level 1", loop_bank, 2'b01);
    loop_enter = 1'b1; step(); idle();
    chk("R10 bank at level 2", loop_bank, 2'b10);
    loop_enter = 1'b1; step(); idle();
    chk("R10 bank at level 3", loop_bank, 2'b11);
    chk("R9 no error yet", loop_ovf_err, 1'b0);
    loop_enter = 1'b1; step(); idle();
    chk("R9 saturate at 3", ccr_q[15:14], 2'b11);
    chk("R9 error pulse", loop_ovf_err, 1'b1);
    step();
    chk("R9 error drops", loop_ovf_err, 1'b0);
    loop_enter = 1'b1; loop_exit = 1'b1; step(); idle();
    chk("R9 enter and exit together", ccr_q[15:14], 2'b11);
    for (int k = 0; k < 3; k++) begin
      loop_exit = 1'b1; step(); idle();
    end
    chk("R9 back to 0", ccr_q[15:14], 2'b00);
    chk("R10 bank at level 0", loop_bank, 2'b01);
    loop_exit = 1'b1; step(); idle();
    chk("R9 saturate at 0", ccr_q[15:14], 2'b00);
    chk("R9 no error on underflow", loop_ovf_err, 1'b0);
    chk("R1 reserved bits", {ccr_q[13], ccr_q[1:0]}, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule